// File: doc/BRIEF.md
# Manchester II Frame Encoder

This block turns a word of programmable length into a Manchester II frame on a two-wire, active-low bipolar line. Each frame holds three bit periods of sync, then K data bits sent most significant bit first, then one parity bit. K can be anything from 2 to 28, so a frame lasts K+4 bit periods (6 to 32). The sync type and the parity sense are chosen per frame. Both are taken at the bit boundary where the frame starts.

The block runs from `clk`, which ticks at twice the bit rate, so one clock is one half-bit. It produces `shift_clk` by dividing `clk` by two. Serial data arrives as a ready/data pair: the encoder raises `bit_ready` for one bit period per data bit and captures `bit_data` at the rising edge of `shift_clk` in that period. The host cannot apply back-pressure and there is no valid signal, because line timing is fixed. The host must place the next bit on `bit_data` whenever `bit_ready` is high, and a missing bit is sent as whatever value is present. While `enc_en` stays high, frames follow one another with no gap. `line_inh_n` idles the line without disturbing the sequencing.

Top module: `manchester_frame_enc`

## Requirements
- R1: While `mrst` is high at a `clk` rising edge, the encoder aborts any frame. After that edge both line outputs are high, `bit_ready` is low and `shift_clk` is low.
- R2: `shift_clk` toggles on every `clk` edge. It is low in the first half of each bit period and high in the second half.
- R3: A frame starts at a bit boundary (the falling edge of `shift_clk`) when `enc_en` is high and `word_len` holds K in plain binary, with 2 <= K <= 28. The frame lasts K+4 bit periods.
- R4: In bit periods 0..2, `sync_cmd`=1 gives three positive half-bits followed by three negative half-bits. `sync_cmd`=0 gives the inverse. Positive means `line_pos_n`=0 and `line_neg_n`=1; negative is the opposite.
- R5: Bit periods 3..K+2 carry the data bits, MSB first. A one is sent as a positive first half and a negative second half; a zero is the inverse.
- R6: `bit_ready` is high in bit periods 2..K+1, which is exactly K periods. The bit captured at the rising `shift_clk` edge of period p is sent in period p+1.
- R7: Bit period K+3 carries parity, encoded like a data bit. With `par_odd`=1 the data bits plus the parity bit hold an odd number of ones; with `par_odd`=0 they hold an even number.
- R8: If `enc_en` is high at the last boundary of a frame, the next frame's sync begins on the very next half-bit.
- R9: If `enc_en` is low at a frame's last boundary, the line returns to idle: both outputs high and `bit_ready` low.
- R10: A `word_len` of 0, 1 or 29..31 starts no frame. The line stays idle and `bit_ready` stays low.
- R11: While `line_inh_n` is low, both line outputs are high. The frame keeps advancing underneath, so once the inhibit is released the output is exactly what it would have been.
- R12: `sync_cmd`, `par_odd` and `word_len` are used only at the starting boundary. Changing them mid-frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Send clock, twice the bit rate |
| mrst | input | 1 | Master reset / abort, active high, synchronous |
| enc_en | input | 1 | Request frames while high |
| sync_cmd | input | 1 | 1: command sync, 0: data sync |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| word_len | input | 5 | Data bit count K (2..28 valid) |
| line_inh_n | input | 1 | Active-low line inhibit |
| bit_data | input | 1 | Serial data from host |
| bit_ready | output | 1 | Encoder wants a data bit this period |
| shift_clk | output | 1 | Send clock divided by two |
| line_pos_n | output | 1 | Active-low positive line drive |
| line_neg_n | output | 1 | Active-low negative line drive |

## Verification
A table of frames covers both sync types, both parity senses, the shortest and longest lengths, and words of all zeros, all ones, a single one and alternating patterns. Comparing each half-bit against the expected waveform separates errors in sync polarity, bit order, half-bit order and parity sense. The config inputs are flipped mid-frame to show they are latched only at the start. Directed runs cover back-to-back frames (a gap or a lost boundary shows up), inhibit in the middle of a frame (a stalled sequencer would shift the rest of the frame), out-of-range lengths, and a reset that aborts a frame before a clean restart.

// File: rtl/mfe_pkg.sv
`timescale 1ns/1ps
package mfe_pkg;
  localparam int SYNC_BITS = 3;
  typedef enum logic {SYNC_DATA = 1'b0, SYNC_CMD = 1'b1} sync_kind_e;
endpackage

// File: rtl/mfe_phase.sv
`timescale 1ns/1ps
module mfe_phase (
  input  logic clk,
  input  logic mrst,
  output logic ph
);
  always_ff @(posedge clk) begin
    if (mrst) ph <= 1'b0;
    else      ph <= ~ph;
  end

  // R2
  ph_toggle_chk: assert property (@(posedge clk) disable iff (mrst)
    1'b1 |=> ph != $past(ph));
endmodule

// File: rtl/mfe_seq.sv
`timescale 1ns/1ps
module mfe_seq import mfe_pkg::*; #(
  parameter int LEN_W = 5,
  parameter int K_MIN = 2,
  parameter int K_MAX = 28,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             ph,
  input  logic             en,
  input  logic [LEN_W-1:0] len,
  input  logic             cmd_sel,
  input  logic             odd_sel,
  output logic             active,
  output logic [CNT_W-1:0] bitcnt,
  output logic [LEN_W-1:0] k_lat,
  output sync_kind_e       kind_lat,
  output logic             odd_lat
);
  localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(K_MIN);
  localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(K_MAX);

  logic             len_ok, at_last, begin_frame;
  logic [CNT_W-1:0] last_idx;

  assign len_ok      = (len >= LEN_LO) && (len <= LEN_HI);
  assign last_idx    = CNT_W'(k_lat) + CNT_W'(SYNC_BITS);
  assign at_last     = active && (bitcnt == last_idx);
  assign begin_frame = ph && (!active || at_last) && en && len_ok;

  always_ff @(posedge clk) begin
    if (mrst) begin
      active   <= 1'b0;
      bitcnt   <= '0;
      k_lat    <= '0;
      kind_lat <= SYNC_DATA;
      odd_lat  <= 1'b0;
    end else if (ph) begin
      if (begin_frame) begin
        active   <= 1'b1;
        bitcnt   <= '0;
        k_lat    <= len;
        kind_lat <= cmd_sel ? SYNC_CMD : SYNC_DATA;
        odd_lat  <= odd_sel;
      end else if (at_last) begin
        active <= 1'b0;
      end else if (active) begin
        bitcnt <= bitcnt + 1'b1;
      end
    end
  end

  // R3
  start_align_chk: assert property (@(posedge clk) disable iff (mrst)
    $rose(active) |-> $past(ph));
  // R3
  frame_len_chk: assert property (@(posedge clk) disable iff (mrst)
    active |-> bitcnt <= last_idx);
  // R12
  cfg_hold_chk: assert property (@(posedge clk) disable iff (mrst)
    (active && bitcnt != '0) |-> ($stable(k_lat) && $stable(kind_lat) && $stable(odd_lat)));
endmodule

// File: rtl/mfe_shift.sv
`timescale 1ns/1ps
module mfe_shift import mfe_pkg::*; #(
  parameter int LEN_W = 5,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             ph,
  input  logic             active,
  input  logic [CNT_W-1:0] bitcnt,
  input  logic [LEN_W-1:0] k_lat,
  input  logic             odd_lat,
  input  logic             sdi,
  output logic             bit_ready,
  output logic             cur_bit
);
  localparam logic [CNT_W-1:0] REQ_FIRST = CNT_W'(SYNC_BITS - 1);

  logic [CNT_W-1:0] req_last, par_idx;
  logic             hold, acc;

  assign req_last  = CNT_W'(k_lat) + CNT_W'(SYNC_BITS - 2);
  assign par_idx   = CNT_W'(k_lat) + CNT_W'(SYNC_BITS - 1);
  assign bit_ready = active && (bitcnt >= REQ_FIRST) && (bitcnt <= req_last);

  always_ff @(posedge clk) begin
    if (mrst) begin
      hold    <= 1'b0;
      acc     <= 1'b0;
      cur_bit <= 1'b0;
    end else if (!ph) begin
      if (bit_ready) begin
        hold <= sdi;
        acc  <= (bitcnt == REQ_FIRST) ? sdi : (acc ^ sdi);
      end
    end else if (active) begin
      if (bit_ready)              cur_bit <= hold;
      else if (bitcnt == par_idx) cur_bit <= acc ^ odd_lat;
    end
  end

  // R6
  ready_span_chk: assert property (@(posedge clk) disable iff (mrst)
    (bit_ready && !ph) |=> bit_ready);
endmodule

// File: rtl/mfe_line.sv
`timescale 1ns/1ps
module mfe_line import mfe_pkg::*; #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             ph,
  input  logic             active,
  input  logic [CNT_W-1:0] bitcnt,
  input  sync_kind_e       kind_lat,
  input  logic             cur_bit,
  input  logic             inh_n,
  output logic             pos_n,
  output logic             neg_n
);
  localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(SYNC_BITS);

  logic [2:0] half_idx;
  logic       in_sync, sync_first, level_pos, drive;

  assign in_sync    = bitcnt < SYNC_END;
  assign half_idx   = {bitcnt[1:0], ph};
  assign sync_first = half_idx < 3'd3;

  always_comb begin
    if (in_sync) level_pos = (kind_lat == SYNC_CMD) ? sync_first : !sync_first;
    else         level_pos = cur_bit ^ ph;
  end

  assign drive = active && inh_n;
  assign pos_n = !(drive && level_pos);
  assign neg_n = !(drive && !level_pos);

  // R4
  no_short_chk: assert property (@(posedge clk) disable iff (mrst)
    !(!pos_n && !neg_n));
  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (mrst)
    !active |-> (pos_n && neg_n));
  // R5
  mid_bit_chk: assert property (@(posedge clk) disable iff (mrst)
    (active && $past(active) && inh_n && $past(inh_n) && !in_sync && ph) |-> (pos_n == $past(neg_n)));
endmodule

// File: rtl/manchester_frame_enc.sv
`timescale 1ns/1ps
module manchester_frame_enc import mfe_pkg::*; #(
  parameter int LEN_W = 5,
  parameter int K_MIN = 2,
  parameter int K_MAX = 28
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             enc_en,
  input  logic             sync_cmd,
  input  logic             par_odd,
  input  logic [LEN_W-1:0] word_len,
  input  logic             line_inh_n,
  input  logic             bit_data,
  output logic             bit_ready,
  output logic             shift_clk,
  output logic             line_pos_n,
  output logic             line_neg_n
);
  localparam int CNT_W = $clog2(K_MAX + SYNC_BITS + 1);

  logic             ph, active, odd_lat, cur_bit;
  logic [CNT_W-1:0] bitcnt;
  logic [LEN_W-1:0] k_lat;
  sync_kind_e       kind_lat;

  mfe_phase u_phase (.clk(clk), .mrst(mrst), .ph(ph));

  mfe_seq #(.LEN_W(LEN_W), .K_MIN(K_MIN), .K_MAX(K_MAX), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .mrst(mrst), .ph(ph), .en(enc_en), .len(word_len),
    .cmd_sel(sync_cmd), .odd_sel(par_odd), .active(active), .bitcnt(bitcnt),
    .k_lat(k_lat), .kind_lat(kind_lat), .odd_lat(odd_lat));

  mfe_shift #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .mrst(mrst), .ph(ph), .active(active), .bitcnt(bitcnt),
    .k_lat(k_lat), .odd_lat(odd_lat), .sdi(bit_data),
    .bit_ready(bit_ready), .cur_bit(cur_bit));

  mfe_line #(.CNT_W(CNT_W)) u_line (
    .clk(clk), .mrst(mrst), .ph(ph), .active(active), .bitcnt(bitcnt),
    .kind_lat(kind_lat), .cur_bit(cur_bit), .inh_n(line_inh_n),
    .pos_n(line_pos_n), .neg_n(line_neg_n));

  assign shift_clk = ph;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(mrst) |-> (line_pos_n && line_neg_n && !bit_ready && !shift_clk));
endmodule

// File: tb/sim_manchester_frame_enc.sv
`timescale 1ns/1ps
module sim_manchester_frame_enc;
  localparam int CLK_PERIOD = 10;
  // fields: [34:30] K, [29] command sync, [28] odd parity, [27:0] word
  localparam logic [34:0] VEC [0:5] = '{
    {5'd16, 1'b1, 1'b1, 28'h000A5C3},
    {5'd2,  1'b0, 1'b0, 28'h0000002},
    {5'd28, 1'b0, 1'b1, 28'hFFFFFFF},
    {5'd5,  1'b1, 1'b0, 28'h0000000},
    {5'd8,  1'b0, 1'b1, 28'h0000001},
    {5'd28, 1'b1, 1'b0, 28'h5A5A5A5}
  };

  logic clk = 1'b0, mrst = 1'b1, enc_en = 1'b0, sync_cmd = 1'b0, par_odd = 1'b0;
  logic [4:0] word_len = 5'd0;
  logic line_inh_n = 1'b1, bit_data = 1'b0;
  logic bit_ready, shift_clk, line_pos_n, line_neg_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  manchester_frame_enc u0 (
    .clk(clk), .mrst(mrst), .enc_en(enc_en), .sync_cmd(sync_cmd), .par_odd(par_odd),
    .word_len(word_len), .line_inh_n(line_inh_n), .bit_data(bit_data),
    .bit_ready(bit_ready), .shift_clk(shift_clk),
    .line_pos_n(line_pos_n), .line_neg_n(line_neg_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, "line {pos_n,neg_n} idle", {line_pos_n, line_neg_n}, 3);
    chk(req, "bit_ready idle", bit_ready, 0);
  endtask

  // align so the next rising clk edge is a bit boundary, then request a frame
  task automatic start(input int k, input bit cmd, input bit odd);
    @(negedge clk);
    while (!shift_clk) @(negedge clk);
    enc_en = 1'b1; word_len = 5'(k); sync_cmd = cmd; par_odd = odd;
  endtask

  task automatic run_frame(input int k, input bit cmd, input bit odd, input logic [27:0] w,
                           input bit keep, input int inh_lo, input int inh_hi, input string sreq);
    int fed = 0;
    bit par = odd;
    for (int j = 0; j < k; j++) par ^= w[j];
    for (int i = 0; i < 2*(k+4); i++) begin
      int bp = i / 2;
      bit hf = i[0];
      bit inh = (i >= inh_lo) && (i <= inh_hi);
      bit pos;
      string req;
      @(negedge clk);
      if (i == 0 && !keep) enc_en = 1'b0;
      if (i == 1 && !keep) begin sync_cmd = !cmd; par_odd = !odd; word_len = 5'd7; end
      line_inh_n = !inh;
      #1;
      if (bp < 3) begin pos = cmd ? (i < 3) : !(i < 3); req = "R4 R12"; end
      else if (bp < 3 + k) begin pos = w[k-1-(bp-3)] ^ hf; req = "R5"; end
      else begin pos = par ^ hf; req = "R7 R12"; end
      if (inh) req = "R11";
      chk(req, $sformatf("line half %0d", i), {line_pos_n, line_neg_n},
          inh ? 3 : (pos ? 1 : 2));
      if (i == 0) chk(sreq, "frame start not idle", (line_pos_n && line_neg_n) ? 1 : 0, inh ? 1 : 0);
      chk("R6", $sformatf("bit_ready half %0d", i), bit_ready, (bp >= 2 && bp <= k+1) ? 1 : 0);
      chk("R2", $sformatf("shift_clk half %0d", i), shift_clk, hf);
      if (bit_ready && !shift_clk && fed < k) begin
        bit_data = w[k-1-fed];
        fed++;
      end
    end
    chk("R6", "bits requested", fed, k);
    line_inh_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk_idle("R1");
    chk("R1", "shift_clk in reset", shift_clk, 0);
    mrst = 1'b0;

    for (int v = 0; v < 6; v++) begin
      int k = int'(VEC[v][34:30]);
      start(k, VEC[v][29], VEC[v][28]);
      run_frame(k, VEC[v][29], VEC[v][28], VEC[v][27:0], 1'b0, -1, -2, "R3");
      @(negedge clk); #1;
      chk_idle("R9");
    end

    // back-to-back frames
    start(3, 1'b0, 1'b1);
    run_frame(3, 1'b0, 1'b1, 28'h5, 1'b1, -1, -2, "R3");
    run_frame(3, 1'b0, 1'b1, 28'h2, 1'b0, -1, -2, "R8");
    @(negedge clk); #1;
    chk_idle("R9");

    // inhibit mid-frame
    start(6, 1'b0, 1'b1);
    run_frame(6, 1'b0, 1'b1, 28'h2D, 1'b0, 4, 11, "R3");
    @(negedge clk); #1;
    chk_idle("R9");

    // out-of-range lengths
    foreach (VEC[q]) begin end
    for (int t = 0; t < 4; t++) begin
      int bad = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 29 : 31;
      @(negedge clk);
      enc_en = 1'b1; word_len = 5'(bad);
      for (int c = 0; c < 10; c++) begin
        @(negedge clk); #1;
        chk_idle("R10");
      end
    end
    enc_en = 1'b0;

    // master reset aborts a frame
    start(10, 1'b1, 1'b0);
    for (int c = 0; c < 9; c++) @(negedge clk);
    enc_en = 1'b0;
    mrst = 1'b1;
    @(negedge clk);
    mrst = 1'b0;
    #1;
    chk_idle("R1");
    chk("R1", "shift_clk after abort", shift_clk, 0);
    start(4, 1'b1, 1'b0);
    run_frame(4, 1'b1, 1'b0, 28'h9, 1'b0, -1, -2, "R1");
    @(negedge clk); #1;
    chk_idle("R9");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule